// File: doc/BRIEF.md
# Scan Self-Test Pattern and Signature Datapath

This block is the data path of a scan-based logic self-test. A 16-bit linear feedback shift register with a maximal-length feedback polynomial produces a pseudo-random bit stream. A network of XOR gates turns its state into eight separate chain inputs, so eight scan chains are fed from one short register. Each chain input has its own multiplexer, which passes either an external scan-in pin or the generated bit.

On the return side, the eight chain outputs are folded by XOR into four bits. Those four bits are merged into a 16-bit multiple-input signature register. Pattern generation and response compaction advance together on every cycle in which shift-enable is high. Once a run is finished, the signature can be compared on chip against a reference value given at a port. It can also be unloaded one bit per cycle through a serial output.

The scan chains themselves sit outside the block, and so does the sequencing that decides when to shift, capture or unload.

Top module: `selftest_datapath`

## Requirements
- R1: After reset the pattern register holds 16'h0001 and the signature register holds 16'h0000.
- R2: When seedLoad is high, the pattern register loads seedVal on the next edge, or 16'h0001 if seedVal is zero. A seed load takes priority over stepping by shiftEn.
- R3: When shiftEn is high and seedLoad is low, the pattern register steps as next = {s[14:0],0} XOR (s[15] ? 16'hA011 : 0), which encodes x^16+x^15+x^13+x^4+1. With both inputs low it holds its value.
- R4: With extSel[i]=0, chainIn[i] is the XOR of pattern bits i, (i+5) mod 16 and (i+11) mod 16 of the current pattern state.
- R5: With extSel[i]=1, chainIn[i] equals extScanIn[i].
- R6: The compacted response bit j (j=0..3) is chainOut[j] XOR chainOut[j+4].
- R7: When shiftEn is high and sigClear is low, the signature register updates as next = {m[14:0],0} XOR (m[15] ? 16'hA011 : 0) XOR {12'b0, compacted}. When sigClear, shiftEn and sigUnload are all low, the signature register holds its value.
- R8: sigClear zeroes the signature register on the next edge. It takes priority over shiftEn and sigUnload, and it does not stop the pattern register from stepping.
- R9: When sigUnload is high and both shiftEn and sigClear are low, the signature register shifts left by one with a zero fill. sigSerial always shows bit 15 of the signature register.
- R10: sigMatch is high exactly when the signature register equals refSig, with no register in between.
- R11: After a seed load, stepping the pattern register brings back the seed after exactly 65535 steps and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| seedLoad | input | 1 | Load seedVal into the pattern register |
| seedVal | input | 16 | Seed value |
| shiftEn | input | 1 | Advance pattern and signature together |
| sigClear | input | 1 | Zero the signature register |
| sigUnload | input | 1 | Shift the signature out serially |
| extSel | input | 8 | Per-chain select, 1 = external scan-in |
| extScanIn | input | 8 | External scan-in bits |
| chainOut | input | 8 | Outputs of the eight scan chains |
| refSig | input | 16 | Reference signature for the on-chip compare |
| chainIn | output | 8 | Inputs to the eight scan chains |
| patState | output | 16 | Current pattern register state |
| sigOut | output | 16 | Current signature |
| sigSerial | output | 1 | Serial signature bit (bit 15) |
| sigMatch | output | 1 | Signature equals refSig |

## Verification
The bench loads an all-zero seed. A design that stored the zero would lock the generator at zero and drive constant chain inputs. Seed load and signature clear are raised together with shiftEn, and a wrong priority shows up as a stepped pattern state or a signature that is not cleared. The bench also unloads a whole signature through the serial output: a wrong fill bit or a wrong shift direction leaves nonzero residue or wrong serial bits. It runs a full pattern period, where a non-primitive feedback would return to the seed early. Random mixes of external and generated chain inputs check that each multiplexer picks its source on its own, and that the compactor pairs the correct chains.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  // Strobes from the control decode to the datapath registers.
  typedef struct packed {
    logic lfsrLoad;
    logic lfsrStep;
    logic sigClr;
    logic sigStep;
    logic sigShift;
  } strobe_t;
endpackage

// File: rtl/selftest_ctrl.sv
module selftest_ctrl
  import selftest_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    seedLoad,
  input  logic    shiftEn,
  input  logic    sigClear,
  input  logic    sigUnload,
  output strobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.lfsrLoad = seedLoad;
    strb.lfsrStep = shiftEn && !seedLoad;
    strb.sigClr   = sigClear;
    strb.sigStep  = shiftEn && !sigClear;
    strb.sigShift = sigUnload && !shiftEn && !sigClear;
  end

  // R2: the pattern register is never loaded and stepped in one cycle
  p_lfsr_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.lfsrLoad, strb.lfsrStep}));
  // R8: at most one signature operation per cycle
  p_sig_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sigClr, strb.sigStep, strb.sigShift}));
endmodule

// File: rtl/selftest_dp.sv
module selftest_dp
  import selftest_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int NCHAINS = 8,
  parameter int NCOMP   = 4,
  parameter logic [WIDTH-1:0] POLY = 16'hA011,
  parameter logic [NCHAINS-1:0][WIDTH-1:0] PS_MASKS =
    {16'h1084, 16'h0842, 16'h0421, 16'h8210,
     16'h4108, 16'h2084, 16'h1042, 16'h0821}
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [WIDTH-1:0]   seedVal,
  input  logic [NCHAINS-1:0] extSel,
  input  logic [NCHAINS-1:0] extScanIn,
  input  logic [NCHAINS-1:0] chainOut,
  input  logic [WIDTH-1:0]   refSig,
  output logic [NCHAINS-1:0] chainIn,
  output logic [WIDTH-1:0]   patState,
  output logic [WIDTH-1:0]   sigOut,
  output logic               sigSerial,
  output logic               sigMatch
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0]   lfsr, misr;
  logic [NCHAINS-1:0] phaseBits;
  logic [NCOMP-1:0]   compBits;

  function automatic logic [WIDTH-1:0] galoisStep(input logic [WIDTH-1:0] s);
    return {s[WIDTH-2:0], 1'b0} ^ (s[WIDTH-1] ? POLY : '0);
  endfunction

  // Pattern generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lfsr <= ONE;
    else if (strb.lfsrLoad) lfsr <= (seedVal == '0) ? ONE : seedVal;
    else if (strb.lfsrStep) lfsr <= galoisStep(lfsr);
  end

  // Phase shifter and per-chain source select
  for (genvar i = 0; i < NCHAINS; i++) begin : g_chain
    assign phaseBits[i] = ^(lfsr & PS_MASKS[i]);
    assign chainIn[i]   = extSel[i] ? extScanIn[i] : phaseBits[i];
  end

  // Space compactor: output j folds every chain k with k mod NCOMP == j
  for (genvar j = 0; j < NCOMP; j++) begin : g_comp
    always_comb begin
      compBits[j] = 1'b0;
      for (int k = j; k < NCHAINS; k += NCOMP) compBits[j] ^= chainOut[k];
    end
  end

  // Signature register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              misr <= '0;
    else if (strb.sigClr)   misr <= '0;
    else if (strb.sigStep)  misr <= galoisStep(misr) ^ {{(WIDTH-NCOMP){1'b0}}, compBits};
    else if (strb.sigShift) misr <= {misr[WIDTH-2:0], 1'b0};
  end

  assign patState  = lfsr;
  assign sigOut    = misr;
  assign sigSerial = misr[WIDTH-1];
  assign sigMatch  = (misr == refSig);

  // R11: a maximal-length generator never reaches the all-zero state
  p_never_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);
  // R2: a seed load leaves a non-zero state
  p_seed_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.lfsrLoad |=> lfsr != '0);
  // R3: without load or step the pattern holds
  p_lfsr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.lfsrLoad && !strb.lfsrStep) |=> $stable(lfsr));
  // R8: clear gives an all-zero signature
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.sigClr |=> misr == '0);
  // R7: idle signature holds
  p_misr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sigClr && !strb.sigStep && !strb.sigShift) |=> $stable(misr));
  // R9: unload fills with zero and moves bit 14 into the serial position
  p_unload_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.sigShift |=> (misr[0] == 1'b0) && (sigSerial == $past(misr[WIDTH-2])));
endmodule

// File: rtl/selftest_datapath.sv
module selftest_datapath
  import selftest_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int NCHAINS = 8,
  parameter int NCOMP   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               seedLoad,
  input  logic [WIDTH-1:0]   seedVal,
  input  logic               shiftEn,
  input  logic               sigClear,
  input  logic               sigUnload,
  input  logic [NCHAINS-1:0] extSel,
  input  logic [NCHAINS-1:0] extScanIn,
  input  logic [NCHAINS-1:0] chainOut,
  input  logic [WIDTH-1:0]   refSig,
  output logic [NCHAINS-1:0] chainIn,
  output logic [WIDTH-1:0]   patState,
  output logic [WIDTH-1:0]   sigOut,
  output logic               sigSerial,
  output logic               sigMatch
);
  strobe_t strb;

  selftest_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .shiftEn(shiftEn),
    .sigClear(sigClear), .sigUnload(sigUnload), .strb(strb)
  );

  selftest_dp #(.WIDTH(WIDTH), .NCHAINS(NCHAINS), .NCOMP(NCOMP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .seedVal(seedVal),
    .extSel(extSel), .extScanIn(extScanIn), .chainOut(chainOut),
    .refSig(refSig), .chainIn(chainIn), .patState(patState),
    .sigOut(sigOut), .sigSerial(sigSerial), .sigMatch(sigMatch)
  );
endmodule

// File: tb/selftest_datapath_test.sv
module selftest_datapath_test;
  localparam int L = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, seedLoad, shiftEn, sigClear, sigUnload;
  logic [15:0] seedVal, refSig;
  logic [7:0]  extSel, extScanIn, chainOut, chainIn;
  logic [15:0] patState, sigOut;
  logic        sigSerial, sigMatch;

  int vectors = 0;
  int misses  = 0;
  logic [15:0] mLfsr, mMisr;

  selftest_datapath uut (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedVal(seedVal),
    .shiftEn(shiftEn), .sigClear(sigClear), .sigUnload(sigUnload),
    .extSel(extSel), .extScanIn(extScanIn), .chainOut(chainOut),
    .refSig(refSig), .chainIn(chainIn), .patState(patState),
    .sigOut(sigOut), .sigSerial(sigSerial), .sigMatch(sigMatch)
  );

  // Scan chains modelled as plain shift registers
  logic [L-1:0] chainReg [8];
  always_ff @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (!rstN)        chainReg[i] <= '0;
      else if (shiftEn) chainReg[i] <= {chainReg[i][L-2:0], chainIn[i]};
    end
  end
  always_comb for (int i = 0; i < 8; i++) chainOut[i] = chainReg[i][L-1];

  function automatic logic [15:0] polyStep(input logic [15:0] s);
    logic [15:0] n;
    n = s << 1;
    if (s[15]) n = n ^ 16'hA011;
    return n;
  endfunction

  function automatic logic phaseBit(input logic [15:0] s, input int i);
    return s[i] ^ s[(i + 5) % 16] ^ s[(i + 11) % 16];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  // One cycle: drive at the falling edge, check the combinational outputs, then the registers
  task automatic cycle(input logic ld, input logic [15:0] sd, input logic clr,
                       input logic sh, input logic unl, input logic [7:0] sel,
                       input logic [7:0] ext, input logic [15:0] rs);
    logic [3:0]  comp;
    logic [15:0] nL, nM;
    seedLoad = ld; seedVal = sd; sigClear = clr; shiftEn = sh;
    sigUnload = unl; extSel = sel; extScanIn = ext; refSig = rs;
    #2;
    for (int i = 0; i < 8; i++)
      chk(sel[i] ? "R5 ext source" : "R4 phase bit", 32'(chainIn[i]),
          32'(sel[i] ? ext[i] : phaseBit(mLfsr, i)));
    chk("R9 serial bit", 32'(sigSerial), 32'(mMisr[15]));
    chk("R10 compare", 32'(sigMatch), 32'(mMisr == rs));
    for (int j = 0; j < 4; j++) comp[j] = chainOut[j] ^ chainOut[j + 4];
    nL = ld ? ((sd == 0) ? 16'h0001 : sd) : (sh ? polyStep(mLfsr) : mLfsr);
    if (clr)      nM = 16'h0000;
    else if (sh)  nM = polyStep(mMisr) ^ {12'h000, comp};
    else if (unl) nM = {mMisr[14:0], 1'b0};
    else          nM = mMisr;
    @(negedge clk);
    mLfsr = nL; mMisr = nM;
    chk(ld ? "R2 seed" : "R3 pattern step", 32'(patState), 32'(mLfsr));
    chk(clr ? "R8 clear" : (sh ? "R7 signature (R6 compactor)" : (unl ? "R9 unload" : "R7 hold")),
        32'(sigOut), 32'(mMisr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; seedLoad = 0; seedVal = 0; shiftEn = 0; sigClear = 0;
    sigUnload = 0; extSel = 0; extScanIn = 0; refSig = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 reset pattern", 32'(patState), 32'h0001);
    chk("R1 reset signature", 32'(sigOut), 32'h0000);
    mLfsr = 16'h0001; mMisr = 16'h0000;

    // R2: zero seed becomes 1; load beats shift
    cycle(1, 16'h0000, 0, 1, 0, 8'h00, 8'h00, 16'h0);
    cycle(1, 16'hBEEF, 0, 1, 0, 8'h00, 8'h00, 16'h0);
    // R3: idle hold, then steps through the feedback
    cycle(0, 16'h0, 0, 0, 0, 8'h00, 8'h00, 16'h0);
    repeat (20) cycle(0, 16'h0, 0, 1, 0, 8'h00, 8'h00, 16'h0);
    // R5: all chains external
    repeat (8) cycle(0, 16'h0, 0, 1, 0, 8'hFF, 8'($urandom), 16'h0);
    // R8: clear together with shift and unload; pattern keeps stepping
    cycle(0, 16'h0, 1, 1, 1, 8'h0F, 8'hA5, 16'h0);
    repeat (12) cycle(0, 16'h0, 0, 1, 0, 8'h00, 8'h00, 16'h0);
    // R10: reference equal to the signature
    cycle(0, 16'h0, 0, 0, 0, 8'h00, 8'h00, mMisr);
    // R9: full serial unload empties the register
    repeat (16) cycle(0, 16'h0, 0, 0, 1, 8'h00, 8'h00, 16'h0);
    chk("R9 unload empties", 32'(sigOut), 32'h0000);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 100);
      cycle(r < 3, 16'($urandom), (r >= 3 && r < 6), ($urandom % 4) != 0,
            ($urandom % 5) == 0, 8'($urandom), 8'($urandom),
            ($urandom % 8 == 0) ? mMisr : 16'($urandom));
    end

    // R11: full period check
    cycle(1, 16'hACE1, 0, 0, 0, 8'h00, 8'h00, 16'h0);
    begin
      int ret = 0;
      shiftEn = 1; seedLoad = 0; sigClear = 0; sigUnload = 0;
      for (int k = 1; k <= 65535; k++) begin
        @(negedge clk);
        if (ret == 0 && patState == 16'hACE1) ret = k;
      end
      chk("R11 period", 32'(ret), 32'd65535);
    end
    shiftEn = 0;
    summary();
    $finish;
  end
endmodule